// File: doc/BRIEF.md
# Half-Step Stepper Phase Sequencer with Automatic Recalibration

This block drives the four coil windings of a two-phase stepper motor that positions a head actuator. It walks an eight-state half-step pattern, moving one state for each accepted step event. Host step pulses move it in the direction chosen by a direction input. After power-on the block recalibrates by itself. Once the drive reports ready, each rising edge of the once-per-revolution index signal acts as one outward step. This continues until the home phase state and the track-zero flag are both present.

Every step does two things. It opens a short step-enable window for the power stage. It also restarts a settle timer, and seek complete is held low until that timer has run out. The window and settle lengths are parameters given in clock cycles. Host steps and index pulses are treated as synchronous levels, and only their rising edges count. Current regulation and the analog coil drivers are outside this block.

Top module: `hstep_seq`

## Requirements
- R1: While reset is asserted, the phase state is the home state 3 (coils A2 and B1 driven, so `coil_n_o` = 4'b1001). In the same condition `step_en_o` is low, the settle timer is idle and recalibration is armed.
- R2: The phase state counts through eight states in this fixed order, with active coils in brackets: 0 (A1), 1 (A1+B1), 2 (B1), 3 (A2+B1), 4 (A2), 5 (A2+B2), 6 (B2), 7 (A1+B2). State 0 follows state 7. The `coil_n_o` bit positions are bit0 A1, bit1 A2, bit2 B1, bit3 B2.
- R3: An accepted host step moves the state up by one when `dir_in_i` is 1 and down by one when it is 0, wrapping modulo 8. The state changes at the clock edge where the rising edge of `step_i` is first sampled.
- R4: Coil outputs are active low. Exactly one or two coils are active at all times. A1 is never active together with A2, and B1 is never active together with B2.
- R5: A host step is accepted only when `ready_i` is high and no recalibration is pending. Any other host step leaves the phase state unchanged.
- R6: While recalibration is pending and `ready_i` is high, each rising edge of `index_i` moves the state down by one. An index edge while `ready_i` is low, or once recalibration has ended, has no effect on the state.
- R7: Recalibration is pending while it is armed and the state is not both 3 and `trk0_flag_i` high. `recal_busy_o` shows this. When state 3 and the flag coincide, the arming clears and stays clear until the next reset.
- R8: Each accepted step drives `step_en_o` high for exactly WIN_CYC cycles, starting at the step's clock edge. A new step restarts the window.
- R9: After each accepted step, `seek_done_o` stays low for exactly SETTLE_CYC cycles. A step inside that interval restarts the full interval.
- R10: If the track-zero flag is high at reset, the home state already matches the flag. In that case `seek_done_o` is high at once, with no step taken.
- R11: `seek_done_o` is low whenever recalibration is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Spindle at speed; enables stepping |
| trk0_flag_i | input | 1 | Track-zero optical flag |
| index_i | input | 1 | Once-per-revolution index level |
| step_i | input | 1 | Host step level; a rising edge is a step |
| dir_in_i | input | 1 | 1 steps inward (state up), 0 steps outward (state down) |
| coil_n_o | output | 4 | Active-low coil drives {B2,B1,A2,A1} |
| step_en_o | output | 1 | Step-enable window for the power stage |
| seek_done_o | output | 1 | Heads settled and no recalibration pending |
| recal_busy_o | output | 1 | Recalibration pending |

## Verification
The assertions assume that `step_i` and `index_i` are synchronous levels that stay high for at least one clock. They also assume `trk0_flag_i` changes only between clock edges. The bench drives every input just after a falling edge and holds it through the next rising edge. Its pulses last two cycles, separated by idle gaps. The track-zero flag comes from a behavioural head-position model. That model covers several tracks, but only one of them lines up with state 3, so recalibration must rely on the phase and flag lining up together rather than on the flag alone.

// File: rtl/hstep_pkg.sv
package hstep_pkg;

  typedef logic [2:0] phase_t;

  // Home (track-zero) phase state.
  localparam phase_t PH_HOME = 3'd3;

  // Coil bit positions inside the 4-bit coil vectors.
  localparam int unsigned C_A1 = 0;
  localparam int unsigned C_A2 = 1;
  localparam int unsigned C_B1 = 2;
  localparam int unsigned C_B2 = 3;

  // Active-high coil pattern of each half-step state.
  function automatic logic [3:0] ph_coils(input phase_t ph);
    logic [3:0] c;
    c = '0;
    case (ph)
      3'd0: c[C_A1] = 1'b1;
      3'd1: begin c[C_A1] = 1'b1; c[C_B1] = 1'b1; end
      3'd2: c[C_B1] = 1'b1;
      3'd3: begin c[C_A2] = 1'b1; c[C_B1] = 1'b1; end
      3'd4: c[C_A2] = 1'b1;
      3'd5: begin c[C_A2] = 1'b1; c[C_B2] = 1'b1; end
      3'd6: c[C_B2] = 1'b1;
      default: begin c[C_A1] = 1'b1; c[C_B2] = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/hstep_edge.sv
module hstep_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];

    // A held level yields a single event (R5).
    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i] || !prev_q[i]);
  end

endmodule

// File: rtl/hstep_timer.sv
module hstep_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? CW'(LEN) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // A load always leaves the timer running in the next cycle (R8, R9).
  p_busy_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o);

endmodule

// File: rtl/hstep_phase_ctr.sv
module hstep_phase_ctr
  import hstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       up_i,
  output phase_t     ph_o,
  output logic [3:0] coil_n_o
);

  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = up_i ? phase_t'(ph_q + 3'd1) : phase_t'(ph_q - 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= PH_HOME;
    else if (adv_i) ph_q <= ph_d;
  end

  assign ph_o     = ph_q;
  assign coil_n_o = ~ph_coils(ph_q);

  // Opposite halves of a winding are never driven together (R4).
  p_no_opposed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_n_o[C_A1] | coil_n_o[C_A2]) && (coil_n_o[C_B1] | coil_n_o[C_B2]));

  // One or two coils active (R4).
  p_coil_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~coil_n_o) == 1) || ($countones(~coil_n_o) == 2));

  // The state moves at most one position per cycle (R3).
  p_single_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |->
      (ph_q == phase_t'($past(ph_q) + 3'd1)) || (ph_q == phase_t'($past(ph_q) - 3'd1)));

endmodule

// File: rtl/hstep_seq.sv
module hstep_seq
  import hstep_pkg::*;
#(
  parameter int unsigned WIN_CYC    = 700,
  parameter int unsigned SETTLE_CYC = 900000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_i,
  input  logic       trk0_flag_i,
  input  logic       index_i,
  input  logic       step_i,
  input  logic       dir_in_i,
  output logic [3:0] coil_n_o,
  output logic       step_en_o,
  output logic       seek_done_o,
  output logic       recal_busy_o
);

  localparam int unsigned EV_STEP = 0;
  localparam int unsigned EV_IDX  = 1;

  logic [1:0] rise;
  phase_t     ph;
  logic       recal_q;
  logic       at_home, recal_pend, recal_clr;
  logic       adv, up;
  logic       settle_busy;

  hstep_edge #(.N(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({index_i, step_i}),
    .rise_o (rise)
  );

  // Step arbitration: index drives recalibration, host steps otherwise.
  always_comb begin
    at_home    = (ph == PH_HOME) && trk0_flag_i;
    recal_pend = recal_q && !at_home;
    recal_clr  = recal_q && at_home;
    if (recal_pend) begin
      adv = ready_i && rise[EV_IDX];
      up  = 1'b0;
    end else begin
      adv = ready_i && rise[EV_STEP];
      up  = dir_in_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         recal_q <= 1'b1;
    else if (recal_clr) recal_q <= 1'b0;
  end

  hstep_phase_ctr u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .up_i     (up),
    .ph_o     (ph),
    .coil_n_o (coil_n_o)
  );

  hstep_timer #(.LEN(WIN_CYC)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (adv),
    .busy_o (step_en_o)
  );

  hstep_timer #(.LEN(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (adv),
    .busy_o (settle_busy)
  );

  assign seek_done_o  = !settle_busy && !recal_pend;
  assign recal_busy_o = recal_pend;

  // Without ready the heads never move (R5, R6).
  p_hold_unready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> (ph == $past(ph)));

  // A recalibration index edge moves outward by one state (R6).
  p_recal_outward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (recal_pend && ready_i && rise[EV_IDX]) |=> (ph == phase_t'($past(ph) - 3'd1)));

  // Once disarmed, recalibration stays off (R7).
  p_recal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !recal_q |=> !recal_q);

  // A new window coincides with an unsettled head (R9).
  p_window_unsettled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_en_o) |-> !seek_done_o);

  // Pending recalibration keeps seek complete low (R11).
  p_no_done_in_recal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    recal_busy_o |-> !seek_done_o);

endmodule

// File: tb/hstep_seq_tb.sv
module hstep_seq_tb;

  localparam int WIN    = 4;
  localparam int SETTLE = 20;
  localparam int WD     = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready_i = 1'b0, trk0_flag_i = 1'b0, index_i = 1'b0, step_i = 1'b0, dir_in_i = 1'b0;
  logic [3:0] coil_n_o;
  logic step_en_o, seek_done_o, recal_busy_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hstep_seq #(.WIN_CYC(WIN), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .trk0_flag_i(trk0_flag_i),
    .index_i(index_i), .step_i(step_i), .dir_in_i(dir_in_i),
    .coil_n_o(coil_n_o), .step_en_o(step_en_o), .seek_done_o(seek_done_o),
    .recal_busy_o(recal_busy_o)
  );

  // Reference pattern per R2: bit0 A1, bit1 A2, bit2 B1, bit3 B2, active low.
  function automatic logic [3:0] exp_coil_n(input int s);
    case (s)
      0: return 4'b1110;
      1: return 4'b1010;
      2: return 4'b1011;
      3: return 4'b1001;
      4: return 4'b1101;
      5: return 4'b0101;
      6: return 4'b0111;
      default: return 4'b0110;
    endcase
  endfunction

  // Behavioural model plus head-position plant.
  int m_ph, m_win, m_set, m_track, init_track = 16;
  bit m_armed, m_pstep, m_pidx;

  function automatic bit m_pending();
    return m_armed && !(m_ph == 3 && trk0_flag_i);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 3; m_armed = 1; m_win = 0; m_set = 0;
      m_pstep = 0; m_pidx = 0; m_track = init_track;
    end else begin
      bit mv, dir_up, pend;
      pend = m_pending();
      mv = 0; dir_up = 0;
      if (pend) begin
        if (ready_i && index_i && !m_pidx) mv = 1;
      end else if (ready_i && step_i && !m_pstep) begin
        mv = 1; dir_up = dir_in_i;
      end
      if (m_armed && !pend) m_armed = 0;
      if (m_win > 0) m_win--;
      if (m_set > 0) m_set--;
      if (mv) begin
        m_ph = dir_up ? (m_ph + 1) % 8 : (m_ph + 7) % 8;
        m_track += dir_up ? 1 : -1;
        m_win = WIN; m_set = SETTLE;
      end
      m_pstep = step_i; m_pidx = index_i;
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the model; then update the flag plant.
  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      logic [3:0] c;
      c = ~coil_n_o;
      chk("R2 R3 phase", coil_n_o, exp_coil_n(m_ph));
      chk("R4 opposed", {3'b0, (c[0] & c[1]) | (c[2] & c[3])}, 4'b0);
      chk("R4 count", {3'b0, ($countones(c) == 1 || $countones(c) == 2)}, 4'b1);
      chk("R8 window", {3'b0, step_en_o}, {3'b0, m_win != 0});
      chk("R9 R11 seek", {3'b0, seek_done_o}, {3'b0, (m_set == 0) && !m_pending()});
      chk("R7 recal", {3'b0, recal_busy_o}, {3'b0, m_pending()});
    end
    trk0_flag_i = (m_track < 4);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_step(input bit d, input int gap);
    dir_in_i = d; step_i = 1'b1; wait_cyc(2); step_i = 1'b0; wait_cyc(gap);
  endtask

  task automatic pulse_idx(input int gap);
    index_i = 1'b1; wait_cyc(2); index_i = 1'b0; wait_cyc(gap);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    // R1: reset state, heads away from track zero.
    trk0_flag_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset coils", coil_n_o, 4'b1001);
    chk("R1 reset window", {3'b0, step_en_o}, 4'b0);
    chk("R1 reset recal", {3'b0, recal_busy_o}, 4'b1);
    rst_n = 1'b1;
    wait_cyc(3);
    // R6: index without ready has no effect.
    pulse_idx(5);
    chk("R6 index unready", coil_n_o, 4'b1001);
    ready_i = 1'b1;
    pulse_idx(10);
    chk("R6 recal step", coil_n_o, exp_coil_n(2));
    chk("R11 no seek in recal", {3'b0, seek_done_o}, 4'b0);
    // R5: host step during recalibration ignored.
    held = coil_n_o;
    pulse_step(1'b1, 5);
    chk("R5 host step in recal", coil_n_o, held);
    for (int i = 0; i < 15; i++) pulse_idx(25);
    chk("R7 recal done", {3'b0, recal_busy_o}, 4'b0);
    chk("R7 home coils", coil_n_o, 4'b1001);
    wait_cyc(SETTLE);
    chk("R9 settled", {3'b0, seek_done_o}, 4'b1);
    // R6: index after recalibration ignored.
    pulse_idx(5);
    chk("R6 index after recal", coil_n_o, 4'b1001);
    // R3 inward steps, then outward with wrap.
    pulse_step(1'b1, 3);
    chk("R3 up", coil_n_o, exp_coil_n(4));
    pulse_step(1'b1, 3);
    pulse_step(1'b1, 3);
    pulse_step(1'b1, 3);
    pulse_step(1'b1, 3);
    chk("R2 wrap up", coil_n_o, exp_coil_n(0));
    pulse_step(1'b0, 3);
    chk("R3 down wrap", coil_n_o, exp_coil_n(7));
    // R9 retrigger: rapid steps keep seek low.
    for (int i = 0; i < 4; i++) pulse_step(1'b0, 6);
    chk("R9 retrigger low", {3'b0, seek_done_o}, 4'b0);
    wait_cyc(SETTLE);
    chk("R9 settled again", {3'b0, seek_done_o}, 4'b1);
    // R5: no ready, host step ignored.
    ready_i = 1'b0;
    held = coil_n_o;
    pulse_step(1'b1, 5);
    chk("R5 step unready", coil_n_o, held);
    // R10: reset at track zero gives seek complete immediately.
    init_track = 0;
    trk0_flag_i = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset at home", {3'b0, seek_done_o}, 4'b1);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R10 no recal", {3'b0, recal_busy_o}, 4'b0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule